// File: doc/BRIEF.md
# SMBus Clock-Low Timeout Monitor

This block watches a sampled SCL level, alongside pulses that mark START, STOP and the ACK slot of each byte, and looks for three separate SMBus timing violations. The first is a continuous low period on the clock line that runs too long. The second is a target that has stretched the clock for too much total time across a whole message. The third is a controller that has stretched the clock for too much total time inside a single byte segment. All time is measured in ticks of an external prescaler, which is normally set to about one millisecond. Each limit is a programmable tick count, so one block covers the 25 to 35 ms clock-low window, the 25 ms target limit and the 10 ms controller limit.

There are three counters, and each one restarts on a different event. The continuous-low counter restarts whenever SCL is seen high. The target counter restarts at the message boundaries, START and STOP. The controller counter restarts at START, at every ACK slot and at STOP, so it measures the segments START-to-ACK, ACK-to-ACK and ACK-to-STOP. Both cumulative counters add up low time from several separate low periods, and they only advance while the matching party is flagged as stretching.

When a counter reaches its limit, it sets its own sticky flag. That flag stays set until software clears it. When a flag goes from clear to set, the block raises a one-cycle bus-reset request.

Top module: `smb_tmo_mon`

## Requirements
- R1: The continuous-low counter gains one on each tick sampled while `scl_in` is 0, and it returns to zero in any cycle where `scl_in` is 1. `tmo_flag[0]` becomes set after the edge at which a tick brings this count to `thr_low`.
- R2: A threshold of zero turns its check off, and the matching flag never sets however many ticks pass.
- R3: The target counter gains one on each tick that has `scl_in` = 0 and `tgt_ext` = 1, summed across separate low periods. It returns to zero on `start_evt` or `stop_evt` but not on `ack_evt`. `tmo_flag[1]` becomes set when this count reaches `thr_tgt`.
- R4: The controller counter gains one on each tick that has `scl_in` = 0 and `ctl_ext` = 1. It returns to zero on `start_evt`, `ack_evt` or `stop_evt`. `tmo_flag[2]` becomes set when this count reaches `thr_ctl`.
- R5: Neither cumulative counter moves while `scl_in` is 1, while its stretching input is 0, or in a cycle without `tick`.
- R6: Each flag stays set until a 1 arrives on the matching bit of `tmo_clr`. Bit 0 clears the low flag, bit 1 the target flag and bit 2 the controller flag. If a new violation and a clear of the same flag arrive in the same cycle, the flag is left set.
- R7: `bus_rst_req` is high for exactly one cycle, the cycle in which at least one flag goes from clear to set. A violation on a flag that is already set gives no request.
- R8: While `rst` is held, and right after it is released, all flags, all counters and `bus_rst_req` are zero.
- R9: When a counter's restart event and an advancing tick arrive in the same cycle, the restart wins and the count ends at zero.
- R10: A violation is reported once per counting run. If the counter keeps going past its threshold, it does not set the flag again after the flag has been cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse from the time-base prescaler |
| scl_in | input | 1 | Sampled SCL level |
| start_evt | input | 1 | START detected pulse |
| stop_evt | input | 1 | STOP detected pulse |
| ack_evt | input | 1 | ACK-slot pulse, ends a byte segment |
| tgt_ext | input | 1 | Target is stretching the clock |
| ctl_ext | input | 1 | Controller is stretching the clock |
| thr_low | input | CNT_W | Continuous-low limit in ticks, 0 turns it off |
| thr_tgt | input | CNT_W | Target cumulative limit in ticks, 0 turns it off |
| thr_ctl | input | CNT_W | Controller per-segment limit in ticks, 0 turns it off |
| tmo_clr | input | 3 | Per-flag clear strobes: bit 0 low, bit 1 target, bit 2 controller |
| tmo_flag | output | 3 | Sticky flags: bit 0 low, bit 1 target, bit 2 controller |
| bus_rst_req | output | 1 | One-cycle bus-reset request |

## Verification
Some rules hold on every cycle, and the assertions check them there. These are: the restart of each counter after its own events and after SCL goes high; cumulative counts that do not move while the clock is high; flags that never drop without a clear; and a request that only comes with a newly risen flag. Other behaviour depends on a sequence of events, and only the bench scenarios can show it. These cases are: low time added up across separate low periods; ACK ending a controller segment but leaving the target total alone; a restart winning over a tick in the same cycle; a zero threshold turning its check off; set winning over clear; and no second report during one long run.

// File: rtl/smb_tmo_pkg.sv
package smb_tmo_pkg;

    localparam int NUM_CHK = 3;
    localparam int IDX_LOW = 0;
    localparam int IDX_TGT = 1;
    localparam int IDX_CTL = 2;

    typedef logic [NUM_CHK-1:0] chk_vec_t;

    typedef struct packed {
        logic stop;
        logic ack;
        logic start;
    } frame_evt_t;

    typedef struct packed {
        logic ctl_ext;
        logic tgt_ext;
        logic scl_low;
        logic tick;
    } line_state_t;

    // Which counters restart this cycle.
    function automatic chk_vec_t restart_vec(frame_evt_t ev, line_state_t ls);
        chk_vec_t v;
        v[IDX_LOW] = !ls.scl_low;
        v[IDX_TGT] = ev.start | ev.stop;
        v[IDX_CTL] = ev.start | ev.stop | ev.ack;
        return v;
    endfunction

    // Which counters take a step this cycle.
    function automatic chk_vec_t advance_vec(line_state_t ls);
        chk_vec_t v;
        v[IDX_LOW] = ls.tick & ls.scl_low;
        v[IDX_TGT] = ls.tick & ls.scl_low & ls.tgt_ext;
        v[IDX_CTL] = ls.tick & ls.scl_low & ls.ctl_ext;
        return v;
    endfunction

endpackage

// File: rtl/smb_tmo_acc.sv
module smb_tmo_acc #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             advance,
    input  logic [CNT_W-1:0] limit,
    output logic             hit,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_inc;
    logic             at_max;

    assign at_max  = &cnt_q;
    assign cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};

    // A hit is the single step that lands exactly on the limit.
    assign hit = advance && !restart && !at_max &&
                 (limit != '0) && (cnt_inc == {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (advance && !at_max) begin
            cnt_q <= cnt_inc[CNT_W-1:0];
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/smb_tmo_flags.sv
module smb_tmo_flags
    import smb_tmo_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  chk_vec_t hit,
    input  chk_vec_t clr,
    output chk_vec_t flag,
    output logic     req
);

    chk_vec_t flag_q;
    logic     req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
            req_q  <= 1'b0;
        end else begin
            flag_q <= (flag_q & ~clr) | hit;
            req_q  <= |(hit & ~flag_q);
        end
    end

    assign flag = flag_q;
    assign req  = req_q;

endmodule

// File: rtl/smb_tmo_mon.sv
module smb_tmo_mon
    import smb_tmo_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             scl_in,
    input  logic             start_evt,
    input  logic             stop_evt,
    input  logic             ack_evt,
    input  logic             tgt_ext,
    input  logic             ctl_ext,
    input  logic [CNT_W-1:0] thr_low,
    input  logic [CNT_W-1:0] thr_tgt,
    input  logic [CNT_W-1:0] thr_ctl,
    input  logic [2:0]       tmo_clr,
    output logic [2:0]       tmo_flag,
    output logic             bus_rst_req
);

    frame_evt_t  ev;
    line_state_t ls;
    chk_vec_t    restart_v;
    chk_vec_t    advance_v;
    chk_vec_t    hit_v;
    chk_vec_t    flag_v;
    logic [NUM_CHK-1:0][CNT_W-1:0] limit_v;
    logic [NUM_CHK-1:0][CNT_W-1:0] cnt_all;

    assign ev = '{stop: stop_evt, ack: ack_evt, start: start_evt};
    assign ls = '{ctl_ext: ctl_ext, tgt_ext: tgt_ext,
                  scl_low: !scl_in, tick: tick};

    assign restart_v = restart_vec(ev, ls);
    assign advance_v = advance_vec(ls);

    assign limit_v[IDX_LOW] = thr_low;
    assign limit_v[IDX_TGT] = thr_tgt;
    assign limit_v[IDX_CTL] = thr_ctl;

    for (genvar i = 0; i < NUM_CHK; i++) begin : g_chk
        smb_tmo_acc #(.CNT_W(CNT_W)) u_acc (
            .clk     (clk),
            .rst     (rst),
            .restart (restart_v[i]),
            .advance (advance_v[i]),
            .limit   (limit_v[i]),
            .hit     (hit_v[i]),
            .count   (cnt_all[i])
        );
    end

    smb_tmo_flags u_flags (
        .clk  (clk),
        .rst  (rst),
        .hit  (hit_v),
        .clr  (tmo_clr),
        .flag (flag_v),
        .req  (bus_rst_req)
    );

    assign tmo_flag = flag_v;

endmodule

// File: rtl/smb_tmo_chk.sv
module smb_tmo_chk
    import smb_tmo_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          scl_in,
    input logic                          start_evt,
    input logic                          stop_evt,
    input logic                          ack_evt,
    input logic [2:0]                    tmo_clr,
    input logic [2:0]                    tmo_flag,
    input logic                          bus_rst_req,
    input logic [NUM_CHK-1:0][CNT_W-1:0] cnt_all
);

    // R1: a high SCL sample restarts the continuous-low count
    p_low_restart_r1: assert property (@(posedge clk) disable iff (rst)
        scl_in |=> (cnt_all[IDX_LOW] == '0));

    // R3: message boundaries restart the target count
    p_tgt_restart_r3: assert property (@(posedge clk) disable iff (rst)
        (start_evt || stop_evt) |=> (cnt_all[IDX_TGT] == '0));

    // R4: START, ACK and STOP restart the controller count
    p_ctl_restart_r4: assert property (@(posedge clk) disable iff (rst)
        (start_evt || ack_evt || stop_evt) |=> (cnt_all[IDX_CTL] == '0));

    // R5: no cumulative progress while the clock is high
    p_tgt_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (scl_in && !start_evt && !stop_evt) |=> $stable(cnt_all[IDX_TGT]));

    p_ctl_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (scl_in && !start_evt && !stop_evt && !ack_evt)
            |=> $stable(cnt_all[IDX_CTL]));

    // R6: a flag only drops under its own clear bit
    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((tmo_flag & $past(tmo_flag & ~tmo_clr)) ==
                  $past(tmo_flag & ~tmo_clr)));

    // R7: a request always comes with a newly set flag
    p_req_with_rise_r7: assert property (@(posedge clk) disable iff (rst)
        bus_rst_req |-> ((tmo_flag & ~$past(tmo_flag)) != 3'b000));

endmodule

bind smb_tmo_mon smb_tmo_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .scl_in      (scl_in),
    .start_evt   (start_evt),
    .stop_evt    (stop_evt),
    .ack_evt     (ack_evt),
    .tmo_clr     (tmo_clr),
    .tmo_flag    (tmo_flag),
    .bus_rst_req (bus_rst_req),
    .cnt_all     (cnt_all)
);

// File: tb/sim_smb_tmo_mon.sv
module sim_smb_tmo_mon;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             tick = 1'b0;
    logic             scl_in = 1'b1;
    logic             start_evt = 1'b0;
    logic             stop_evt = 1'b0;
    logic             ack_evt = 1'b0;
    logic             tgt_ext = 1'b0;
    logic             ctl_ext = 1'b0;
    logic [CNT_W-1:0] thr_low = 16'd4;
    logic [CNT_W-1:0] thr_tgt = 16'd3;
    logic [CNT_W-1:0] thr_ctl = 16'd2;
    logic [2:0]       tmo_clr = 3'b000;
    logic [2:0]       tmo_flag;
    logic             bus_rst_req;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    string      tag_q[$];
    logic [2:0] flag_q[$];
    logic       req_q[$];

    always #10 clk = ~clk;

    smb_tmo_mon #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .scl_in(scl_in),
        .start_evt(start_evt), .stop_evt(stop_evt), .ack_evt(ack_evt),
        .tgt_ext(tgt_ext), .ctl_ext(ctl_ext),
        .thr_low(thr_low), .thr_tgt(thr_tgt), .thr_ctl(thr_ctl),
        .tmo_clr(tmo_clr), .tmo_flag(tmo_flag), .bus_rst_req(bus_rst_req)
    );

    // Driver: apply one cycle of stimulus, then queue what must follow.
    task automatic cyc(input logic tk, input logic scl, input logic st,
                       input logic sp, input logic ak, input logic te,
                       input logic ce, input logic [2:0] clr,
                       input logic [2:0] ef, input logic er, input string tag);
        @(negedge clk);
        tick = tk; scl_in = scl; start_evt = st; stop_evt = sp;
        ack_evt = ak; tgt_ext = te; ctl_ext = ce; tmo_clr = clr;
        @(posedge clk);
        #1;
        tag_q.push_back(tag);
        flag_q.push_back(ef);
        req_q.push_back(er);
    endtask

    // Monitor: compare queued expectations away from the clock edge.
    always @(negedge clk) begin
        if (tag_q.size() > 0) begin
            string      t;
            logic [2:0] f;
            logic       r;
            t = tag_q.pop_front();
            f = flag_q.pop_front();
            r = req_q.pop_front();
            checks++;
            if (tmo_flag !== f || bus_rst_req !== r) begin
                errors++;
                $display("FAIL %s: flags=%b req=%b expected flags=%b req=%b",
                         t, tmo_flag, bus_rst_req, f, r);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R8: idle after reset
        cyc(0,1,0,0,0,0,0,3'b000,3'b000,0,"R8 reset state");

        // R1 / R7 / R10: continuous low run
        cyc(1,0,0,0,0,0,0,3'b000,3'b000,0,"R1 low tick 1");
        cyc(1,0,0,0,0,0,0,3'b000,3'b000,0,"R1 low tick 2");
        cyc(1,0,0,0,0,0,0,3'b000,3'b000,0,"R1 low tick 3");
        cyc(1,0,0,0,0,0,0,3'b000,3'b001,1,"R1 low limit reached, R7 pulse");
        cyc(1,0,0,0,0,0,0,3'b001,3'b000,0,"R6 clear low flag");
        cyc(1,0,0,0,0,0,0,3'b000,3'b000,0,"R10 no second report");
        cyc(0,1,0,0,0,0,0,3'b000,3'b000,0,"R7 no pulse while idle");

        // R1: high sample restarts the count
        cyc(1,0,0,0,0,0,0,3'b000,3'b000,0,"R1 run2 tick 1");
        cyc(1,0,0,0,0,0,0,3'b000,3'b000,0,"R1 run2 tick 2");
        cyc(1,0,0,0,0,0,0,3'b000,3'b000,0,"R1 run2 tick 3");
        cyc(0,1,0,0,0,0,0,3'b000,3'b000,0,"R1 high restart");
        cyc(1,0,0,0,0,0,0,3'b000,3'b000,0,"R1 run3 tick 1");
        cyc(1,0,0,0,0,0,0,3'b000,3'b000,0,"R1 run3 tick 2");
        cyc(1,0,0,0,0,0,0,3'b000,3'b000,0,"R1 run3 tick 3");
        cyc(1,0,0,0,0,0,0,3'b000,3'b001,1,"R1 run3 limit");
        cyc(0,1,0,0,0,0,0,3'b001,3'b000,0,"R6 clear low flag again");

        // R3: target total across low periods, ACK leaves it alone
        cyc(0,1,1,0,0,0,0,3'b000,3'b000,0,"R3 start");
        cyc(1,0,0,0,0,1,0,3'b000,3'b000,0,"R3 stretch 1");
        cyc(1,1,0,0,0,1,0,3'b000,3'b000,0,"R5 high tick no count");
        cyc(1,0,0,0,0,1,0,3'b000,3'b000,0,"R3 stretch 2");
        cyc(0,1,0,0,1,1,0,3'b000,3'b000,0,"R3 ack keeps total");
        cyc(1,0,0,0,0,1,0,3'b000,3'b010,1,"R3 target limit");
        cyc(0,1,0,1,0,0,0,3'b010,3'b000,0,"R6 clear target flag");

        // R3: START and STOP restart the target total
        cyc(0,1,1,0,0,0,0,3'b000,3'b000,0,"R3 start b");
        cyc(1,0,0,0,0,1,0,3'b000,3'b000,0,"R3 msg1 stretch 1");
        cyc(1,0,0,0,0,1,0,3'b000,3'b000,0,"R3 msg1 stretch 2");
        cyc(0,1,0,1,0,0,0,3'b000,3'b000,0,"R3 stop restarts");
        cyc(1,0,0,0,0,1,0,3'b000,3'b000,0,"R3 msg2 stretch 1");
        cyc(1,0,0,0,0,1,0,3'b000,3'b000,0,"R3 msg2 stretch 2");
        cyc(0,1,0,1,0,0,0,3'b000,3'b000,0,"R3 stop again");

        // R5: no count without tick, with clock high
        cyc(0,1,1,0,0,0,0,3'b000,3'b000,0,"R5 start");
        cyc(0,0,0,0,0,1,0,3'b000,3'b000,0,"R5 no tick 1");
        cyc(0,0,0,0,0,1,0,3'b000,3'b000,0,"R5 no tick 2");
        cyc(0,0,0,0,0,1,0,3'b000,3'b000,0,"R5 no tick 3");
        cyc(1,1,0,0,0,1,0,3'b000,3'b000,0,"R5 high 1");
        cyc(1,1,0,0,0,1,0,3'b000,3'b000,0,"R5 high 2");
        cyc(1,1,0,0,0,1,0,3'b000,3'b000,0,"R5 high 3");
        cyc(1,0,0,0,0,1,0,3'b000,3'b000,0,"R5 real 1");
        cyc(1,0,0,0,0,1,0,3'b000,3'b000,0,"R5 real 2");
        cyc(1,0,0,0,0,1,0,3'b000,3'b010,1,"R5 limit on third real tick");
        cyc(0,1,0,1,0,0,0,3'b010,3'b000,0,"R6 clear target");

        // R4: controller per-segment total
        cyc(0,1,1,0,0,0,0,3'b000,3'b000,0,"R4 start");
        cyc(1,0,0,0,0,0,1,3'b000,3'b000,0,"R4 seg1 stretch 1");
        cyc(0,1,0,0,1,0,0,3'b000,3'b000,0,"R4 ack restarts");
        cyc(1,0,0,0,0,0,1,3'b000,3'b000,0,"R4 seg2 stretch 1");
        cyc(0,1,0,0,0,0,0,3'b000,3'b000,0,"R4 seg2 high");
        cyc(1,0,0,0,0,0,1,3'b000,3'b100,1,"R4 controller limit");
        cyc(0,1,0,0,1,0,0,3'b000,3'b100,0,"R6 flag holds over ack");
        cyc(1,0,0,0,0,0,1,3'b000,3'b100,0,"R4 seg3 stretch 1");
        cyc(0,1,0,0,0,0,0,3'b000,3'b100,0,"R4 seg3 high");
        cyc(1,0,0,0,0,0,1,3'b000,3'b100,0,"R7 no pulse for set flag");
        cyc(0,1,0,1,0,0,0,3'b100,3'b000,0,"R6 clear controller");

        // R9: restart beats tick; R6: set beats clear
        cyc(1,0,0,0,0,1,0,3'b000,3'b000,0,"R9 stretch 1");
        cyc(0,1,0,0,0,0,0,3'b000,3'b000,0,"R9 high");
        cyc(1,0,0,0,0,1,0,3'b000,3'b000,0,"R9 stretch 2");
        cyc(0,1,0,0,0,0,0,3'b000,3'b000,0,"R9 high b");
        cyc(1,0,1,0,0,1,0,3'b000,3'b000,0,"R9 start with tick");
        cyc(0,1,0,0,0,0,0,3'b000,3'b000,0,"R9 high c");
        cyc(1,0,0,0,0,1,0,3'b000,3'b000,0,"R9 after restart 1");
        cyc(0,1,0,0,0,0,0,3'b000,3'b000,0,"R9 high d");
        cyc(1,0,0,0,0,1,0,3'b000,3'b000,0,"R9 after restart 2");
        cyc(0,1,0,0,0,0,0,3'b000,3'b000,0,"R9 high e");
        cyc(1,0,0,0,0,1,0,3'b010,3'b010,1,"R6 set wins over clear");
        cyc(0,1,0,1,0,0,0,3'b010,3'b000,0,"R6 clear after");

        // R2: zero threshold disables the low check
        @(negedge clk);
        thr_low = '0;
        for (int k = 0; k < 6; k++)
            cyc(1,0,0,0,0,0,0,3'b000,3'b000,0,"R2 disabled low check");
        cyc(0,1,0,0,0,0,0,3'b000,3'b000,0,"R2 idle");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule